// File: doc/BRIEF.md
# Local Bus Slave Target

This block is a synchronous slave for a 32-bit local bus that runs on the processor clock. On every rising clock edge it looks at the active-low address strobe. When the strobe is low, it takes in the dword address, the active-low byte enables, the three cycle-type lines (memory/IO, data/control, write/read) and the burst-last line. A decoder checks the cycle type and the address against one memory window and one I/O window. If the cycle belongs to this slave, the slave claims it by pulling the local-device line low from the next clock on.

A small sequencer then completes the cycle. After a fixed number of wait states it finishes a single transfer with one pulse on the local-ready line. A four-beat memory burst is finished with four pulses on the burst-ready line, and the same number of wait states comes before each pulse. In every ready cycle a register-file style back-end port is active. It carries a dword address that advances by one each beat, the byte strobes, the write data, a write enable and the read data returned in the enabled lanes. An address strobe that arrives while a cycle is still in progress is ignored.

The sequencer has three states:
- IDLE: no cycle in progress.
- WAIT: counting wait states.
- READY: a ready line is low for one clock.

Its transitions are named as follows:
- IDLE→WAIT or IDLE→READY is "claim". It happens on a strobe that hits a window; it goes to READY when there are no wait states.
- WAIT→WAIT is "count".
- WAIT→READY is "expire".
- READY→WAIT or READY→READY is "next beat". It happens inside a burst.
- READY→IDLE is "finish".

Top module: `lbus_target`

## Requirements
- R1: While reset is asserted and after its release, ldev_n, lrdy_n, brdy_n and lbs16_n are high, be_we is low, and the slave is idle.
- R2: A strobe with cycle type {mio,dc,wr} of 3'b110 (memory read), 3'b111 (memory write) or 3'b100 (code fetch) is claimed when the byte address lies in the memory window [MEM_BASE, MEM_BASE+2^MEM_AW). Type 3'b010 (I/O read) or 3'b011 (I/O write) is claimed when the byte address lies in the I/O window [IO_BASE, IO_BASE+2^IO_AW).
- R3: Types 3'b000, 3'b001 and 3'b101 are never claimed, whatever the address. ldev_n, lrdy_n and brdy_n stay high.
- R4: A strobe whose address lies outside the window for its type is not claimed, and all bus outputs stay high.
- R5: For a claimed cycle, ldev_n is low from the clock after the strobe edge through the final ready cycle. It is high again on the clock after the final ready.
- R6: A single transfer (any I/O cycle, or a memory cycle with blast_n low at the strobe) ends with lrdy_n low for exactly one clock. brdy_n stays high throughout.
- R7: A memory cycle with blast_n high at the strobe is a burst. It gives four one-clock brdy_n pulses and no lrdy_n pulse. be_addr is the latched dword address plus the beat number 0 to 3.
- R8: Exactly WAIT_STATES clocks, with both ready lines high, come before each ready pulse. This holds for the first beat and for every later beat.
- R9: be_strb bit i is the inverse of be_n bit i latched at the strobe, and lane i is data bits 8i+7..8i. be_we is high only in the ready cycles of write cycles, and be_wdata equals wdata.
- R10: In the ready cycle of a read, rdata carries be_rdata in the enabled lanes and zero in the disabled lanes. In write ready cycles rdata is zero.
- R11: A strobe that arrives while a cycle is in progress, including in the final ready cycle, is ignored. The slave returns to idle and does not claim it.
- R12: lbs16_n stays high while a cycle is claimed when NARROW16 is 0 (the default). With NARROW16 set to 1 it follows ldev_n.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ads_n | input | 1 | Address strobe, active low |
| addr | input | 30 | Dword address, byte address bits 31..2 |
| be_n | input | 4 | Byte enables, active low |
| mio | input | 1 | Memory (1) or I/O (0) cycle |
| dc | input | 1 | Data (1) or control (0) cycle |
| wr | input | 1 | Write (1) or read (0) |
| blast_n | input | 1 | Burst-last; high at the strobe requests a burst |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, enabled lanes only |
| ldev_n | output | 1 | Local-device claim, active low |
| lrdy_n | output | 1 | Single-transfer ready, active low |
| brdy_n | output | 1 | Burst-beat ready, active low |
| lbs16_n | output | 1 | 16-bit slave indication, active low |
| be_addr | output | 30 | Back-end dword address |
| be_wdata | output | 32 | Back-end write data |
| be_strb | output | 4 | Back-end byte strobes, active high |
| be_we | output | 1 | Back-end write enable |
| be_rdata | input | 32 | Back-end read data |

## Verification
The risky overlap is a fresh address strobe that lands in the same clock as the final ready pulse of a cycle in progress. At that edge the sequencer must both finish the old cycle and refuse the new strobe. The bench drives a valid, in-window memory strobe exactly on the last ready cycle of several singles and bursts. It expects ldev_n to go high on the next clock and to stay high with no ready pulse. A second overlap is the back-end write landing in the same cycle as a ready pulse. For every beat the bench compares address, strobes and data against its own model in that one cycle.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

    // cycle-type code {mio, dc, wr}
    typedef enum logic [2:0] {
        CT_INTA  = 3'b000,
        CT_HALT  = 3'b001,
        CT_IORD  = 3'b010,
        CT_IOWR  = 3'b011,
        CT_FETCH = 3'b100,
        CT_SHUT  = 3'b101,
        CT_MEMRD = 3'b110,
        CT_MEMWR = 3'b111
    } cyc_type_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } seq_state_t;

endpackage

// File: rtl/lbt_decode.sv
module lbt_decode
    import lbt_pkg::*;
#(
    parameter logic [31:0] MEM_BASE = 32'h000C_0000,
    parameter int          MEM_AW   = 16,
    parameter logic [31:0] IO_BASE  = 32'h0000_0300,
    parameter int          IO_AW    = 4
) (
    input  logic [29:0] addr,
    input  logic [2:0]  ctype,
    input  logic        blast_n,
    output logic        claim,
    output logic        is_write,
    output logic        is_burst
);
    localparam logic [29:0] MEM_MASK = ~((30'd1 << (MEM_AW - 2)) - 30'd1);
    localparam logic [29:0] IO_MASK  = ~((30'd1 << (IO_AW - 2)) - 30'd1);

    logic mem_hit, io_hit;

    assign mem_hit = ((addr ^ MEM_BASE[31:2]) & MEM_MASK) == '0;
    assign io_hit  = ((addr ^ IO_BASE[31:2]) & IO_MASK) == '0;

    always_comb begin
        claim    = 1'b0;
        is_burst = 1'b0;
        case (cyc_type_t'(ctype))
            CT_MEMRD, CT_MEMWR, CT_FETCH: begin
                claim    = mem_hit;
                is_burst = mem_hit & blast_n;
            end
            CT_IORD, CT_IOWR: claim = io_hit;
            default: claim = 1'b0;  // interrupt ack, halt, shutdown
        endcase
    end

    assign is_write = ctype[0];

endmodule

// File: rtl/lbt_seq.sv
module lbt_seq
    import lbt_pkg::*;
#(
    parameter int WAIT_STATES = 1,
    parameter int BEATS       = 4,
    parameter int LANES       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_burst,
    input  logic             start_write,
    input  logic [29:0]      start_addr,
    input  logic [LANES-1:0] start_strb,
    output logic             busy,
    output logic             rdy_single,
    output logic             rdy_burst,
    output logic             wr_pulse,
    output logic             rd_pulse,
    output logic [29:0]      cur_addr,
    output logic [LANES-1:0] cur_strb
);
    localparam int WCW = (WAIT_STATES > 2) ? $clog2(WAIT_STATES) : 1;
    localparam int BW  = (BEATS > 2) ? $clog2(BEATS) : 1;
    localparam logic [WCW-1:0] WS_LOAD   = WCW'((WAIT_STATES == 0) ? 0 : WAIT_STATES - 1);
    localparam logic [BW-1:0]  LAST_BEAT = BW'(BEATS - 1);

    seq_state_t       state;
    logic [WCW-1:0]   wcnt;
    logic [BW-1:0]    beat;
    logic             burst_q, write_q;
    logic [29:0]      addr_q;
    logic [LANES-1:0] strb_q;

    // state register and cycle context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            wcnt    <= '0;
            beat    <= '0;
            burst_q <= 1'b0;
            write_q <= 1'b0;
            addr_q  <= '0;
            strb_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin                      // claim
                        burst_q <= start_burst;
                        write_q <= start_write;
                        addr_q  <= start_addr;
                        strb_q  <= start_strb;
                        beat    <= '0;
                        wcnt    <= WS_LOAD;
                        state   <= (WAIT_STATES == 0) ? ST_READY : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wcnt == '0) state <= ST_READY;    // expire
                    else            wcnt  <= wcnt - 1'b1; // count
                end
                ST_READY: begin
                    if (burst_q && beat != LAST_BEAT) begin // next beat
                        beat  <= beat + 1'b1;
                        wcnt  <= WS_LOAD;
                        state <= (WAIT_STATES == 0) ? ST_READY : ST_WAIT;
                    end else begin
                        state <= ST_IDLE;                 // finish
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        busy       = 1'b0;
        rdy_single = 1'b0;
        rdy_burst  = 1'b0;
        wr_pulse   = 1'b0;
        rd_pulse   = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_WAIT: busy = 1'b1;
            ST_READY: begin
                busy       = 1'b1;
                rdy_single = ~burst_q;
                rdy_burst  = burst_q;
                wr_pulse   = write_q;
                rd_pulse   = ~write_q;
            end
            default: busy = 1'b0;
        endcase
    end

    assign cur_addr = addr_q + 30'(beat);
    assign cur_strb = strb_q;

endmodule

// File: rtl/lbt_lanes.sv
module lbt_lanes #(
    parameter int LANES = 4
) (
    input  logic               rd_en,
    input  logic [LANES-1:0]   strb,
    input  logic [8*LANES-1:0] src,
    output logic [8*LANES-1:0] dst
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dst[8*i +: 8] = (rd_en && strb[i]) ? src[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/lbus_target.sv
module lbus_target
    import lbt_pkg::*;
#(
    parameter logic [31:0] MEM_BASE    = 32'h000C_0000,
    parameter int          MEM_AW      = 16,
    parameter logic [31:0] IO_BASE     = 32'h0000_0300,
    parameter int          IO_AW       = 4,
    parameter int          WAIT_STATES = 1,
    parameter int          BEATS       = 4,
    parameter bit          NARROW16    = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ads_n,
    input  logic [29:0] addr,
    input  logic [3:0]  be_n,
    input  logic        mio,
    input  logic        dc,
    input  logic        wr,
    input  logic        blast_n,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        ldev_n,
    output logic        lrdy_n,
    output logic        brdy_n,
    output logic        lbs16_n,
    output logic [29:0] be_addr,
    output logic [31:0] be_wdata,
    output logic [3:0]  be_strb,
    output logic        be_we,
    input  logic [31:0] be_rdata
);
    localparam int LANES = 4;

    logic claim, is_write, is_burst;
    logic busy, rdy_single, rdy_burst, wr_pulse, rd_pulse;

    lbt_decode #(
        .MEM_BASE(MEM_BASE), .MEM_AW(MEM_AW), .IO_BASE(IO_BASE), .IO_AW(IO_AW)
    ) decode_i (
        .addr(addr), .ctype({mio, dc, wr}), .blast_n(blast_n),
        .claim(claim), .is_write(is_write), .is_burst(is_burst)
    );

    lbt_seq #(
        .WAIT_STATES(WAIT_STATES), .BEATS(BEATS), .LANES(LANES)
    ) seq_i (
        .clk(clk), .rst_n(rst_n),
        .start(~ads_n & claim), .start_burst(is_burst), .start_write(is_write),
        .start_addr(addr), .start_strb(~be_n),
        .busy(busy), .rdy_single(rdy_single), .rdy_burst(rdy_burst),
        .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
        .cur_addr(be_addr), .cur_strb(be_strb)
    );

    lbt_lanes #(.LANES(LANES)) lanes_i (
        .rd_en(rd_pulse), .strb(be_strb), .src(be_rdata), .dst(rdata)
    );

    assign ldev_n   = ~busy;
    assign lrdy_n   = ~rdy_single;
    assign brdy_n   = ~rdy_burst;
    assign be_we    = wr_pulse;
    assign be_wdata = wdata;

    if (NARROW16) begin : g_narrow
        assign lbs16_n = ~busy;
    end else begin : g_wide
        assign lbs16_n = 1'b1;
    end

endmodule

// File: rtl/lbt_checker.sv
module lbt_checker #(
    parameter int WAIT_STATES = 1
) (
    input logic clk,
    input logic rst_n,
    input logic ads_n,
    input logic mio,
    input logic dc,
    input logic wr,
    input logic ldev_n,
    input logic lrdy_n,
    input logic brdy_n,
    input logic be_we
);
    logic never_claim;
    assign never_claim = ({mio, dc, wr} == 3'b000) || ({mio, dc, wr} == 3'b001) ||
                         ({mio, dc, wr} == 3'b101);

    assert_ready_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lrdy_n && !brdy_n));

    assert_ready_claimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lrdy_n || !brdy_n) |-> !ldev_n);

    assert_single_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !lrdy_n |=> ldev_n);

    assert_halt_unclaimed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n && ldev_n && never_claim) |=> ldev_n);

    assert_write_in_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        be_we |-> (!lrdy_n || !brdy_n));

    assert_first_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (WAIT_STATES > 0 && $fell(ldev_n)) |-> (lrdy_n && brdy_n));

endmodule

bind lbus_target lbt_checker #(.WAIT_STATES(WAIT_STATES)) checker_i (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mio(mio), .dc(dc), .wr(wr),
    .ldev_n(ldev_n), .lrdy_n(lrdy_n), .brdy_n(brdy_n), .be_we(be_we)
);

// File: tb/lbus_target_tb_top.sv
module lbus_target_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          WS         = 1;
    localparam logic [31:0] MEM_BASE   = 32'h000C_0000;
    localparam int          MEM_AW     = 16;
    localparam logic [31:0] IO_BASE    = 32'h0000_0300;
    localparam int          IO_AW      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ads_n = 1'b1;
    logic [29:0] addr = '0;
    logic [3:0]  be_n = 4'hF;
    logic        mio = 1'b0, dc = 1'b0, wr = 1'b0, blast_n = 1'b1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, be_wdata, be_rdata;
    logic        ldev_n, lrdy_n, brdy_n, lbs16_n, be_we;
    logic [29:0] be_addr;
    logic [3:0]  be_strb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbus_target #(
        .MEM_BASE(MEM_BASE), .MEM_AW(MEM_AW), .IO_BASE(IO_BASE), .IO_AW(IO_AW),
        .WAIT_STATES(WS), .BEATS(4), .NARROW16(1'b0)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .addr(addr), .be_n(be_n),
        .mio(mio), .dc(dc), .wr(wr), .blast_n(blast_n), .wdata(wdata),
        .rdata(rdata), .ldev_n(ldev_n), .lrdy_n(lrdy_n), .brdy_n(brdy_n),
        .lbs16_n(lbs16_n), .be_addr(be_addr), .be_wdata(be_wdata),
        .be_strb(be_strb), .be_we(be_we), .be_rdata(be_rdata)
    );

    function automatic logic [31:0] pattern(input logic [29:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    assign be_rdata = pattern(be_addr);

    function automatic logic [31:0] lane_mask(input logic [3:0] s);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{s[i]}};
        return m;
    endfunction

    function automatic bit exp_claim(input logic [2:0] c, input logic [29:0] a);
        logic [31:0] b;
        b = {a, 2'b00};
        if (c == 3'b110 || c == 3'b111 || c == 3'b100)
            return (b >> MEM_AW) == (MEM_BASE >> MEM_AW);
        if (c == 3'b010 || c == 3'b011)
            return (b >> IO_AW) == (IO_BASE >> IO_AW);
        return 1'b0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one bus cycle; starts and ends just after a falling edge.
    task automatic run_cycle(input logic [2:0] c, input logic [29:0] a, input logic [3:0] strb,
                             input logic bl_n, input logic [31:0] wbase, input bit inject);
        bit claimed, burst;
        int nb;
        logic [31:0] rexp;
        claimed = exp_claim(c, a);
        burst   = claimed && c[2] && bl_n;
        nb      = burst ? 4 : 1;
        ads_n = 1'b0; addr = a; be_n = ~strb; {mio, dc, wr} = c; blast_n = bl_n;
        wdata = wbase;
        @(negedge clk);
        ads_n = 1'b1; addr = ~a;
        if (!claimed) begin
            for (int k = 0; k < 3; k++) begin
                #1;
                chk((c == 3'b000 || c == 3'b001 || c == 3'b101) ? "R3 ldev_n" : "R4 ldev_n",
                    {31'd0, ldev_n}, 32'd1);
                chk("R4 ready lines", {30'd0, lrdy_n, brdy_n}, 32'd3);
                @(negedge clk);
            end
            return;
        end
        for (int k = 0; k < nb; k++) begin
            wdata = wbase + k;
            blast_n = (k == nb - 1) ? 1'b0 : 1'b1;
            for (int w = 0; w < WS; w++) begin
                #1;
                chk("R5 ldev_n in wait", {31'd0, ldev_n}, 32'd0);
                chk("R8 ready high in wait", {30'd0, lrdy_n, brdy_n}, 32'd3);
                chk("R9 be_we low in wait", {31'd0, be_we}, 32'd0);
                @(negedge clk);
            end
            if (inject && k == nb - 1) begin
                ads_n = 1'b0; addr = MEM_BASE[31:2]; {mio, dc, wr} = 3'b110; blast_n = 1'b0;
            end
            #1;
            chk("R5 ldev_n at ready", {31'd0, ldev_n}, 32'd0);
            chk("R12 lbs16_n", {31'd0, lbs16_n}, 32'd1);
            if (burst) chk("R7 ready lines", {30'd0, lrdy_n, brdy_n}, 32'd2);
            else       chk("R6 ready lines", {30'd0, lrdy_n, brdy_n}, 32'd1);
            chk("R7 be_addr", {2'b00, be_addr}, {2'b00, a + 30'(k)});
            chk("R9 be_strb", {28'd0, be_strb}, {28'd0, strb});
            chk("R9 be_we", {31'd0, be_we}, {31'd0, c[0]});
            if (c[0]) chk("R9 be_wdata", be_wdata, wbase + k);
            rexp = c[0] ? 32'd0 : (pattern(a + 30'(k)) & lane_mask(strb));
            chk("R10 rdata", rdata, rexp);
            @(negedge clk);
            ads_n = 1'b1;
        end
        #1;
        chk("R5 ldev_n released", {31'd0, ldev_n}, 32'd1);
        chk("R6 ready lines after", {30'd0, lrdy_n, brdy_n}, 32'd3);
        if (inject) begin
            @(negedge clk); #1;
            chk("R11 late strobe ignored", {31'd0, ldev_n}, 32'd1);
            chk("R11 no ready", {30'd0, lrdy_n, brdy_n}, 32'd3);
        end
    endtask

    function automatic logic [29:0] pick_addr(input int sel);
        logic [31:0] b;
        case (sel)
            0: b = MEM_BASE | ($urandom & 32'h0000_FFFC);
            1: b = IO_BASE | ($urandom & 32'h0000_000C);
            default: b = 32'h0100_0000 | ($urandom & 32'h00FF_FFFC);
        endcase
        return b[31:2];
    endfunction

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        @(negedge clk); #1;
        chk("R1 ldev_n in reset", {31'd0, ldev_n}, 32'd1);
        chk("R1 ready lines in reset", {30'd0, lrdy_n, brdy_n}, 32'd3);
        chk("R1 lbs16_n in reset", {31'd0, lbs16_n}, 32'd1);
        chk("R1 be_we in reset", {31'd0, be_we}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 ldev_n after reset", {31'd0, ldev_n}, 32'd1);
        @(negedge clk);

        // directed corners
        run_cycle(3'b110, MEM_BASE[31:2] + 30'd4, 4'hF, 1'b0, 32'h0, 1'b0); // R2 R6 single read
        run_cycle(3'b111, MEM_BASE[31:2] + 30'd8, 4'h5, 1'b1, 32'hA000_0000, 1'b0); // R7 burst write
        run_cycle(3'b100, MEM_BASE[31:2] + 30'd16, 4'h9, 1'b1, 32'h0, 1'b0); // R7 fetch burst
        run_cycle(3'b011, IO_BASE[31:2] + 30'd1, 4'h2, 1'b1, 32'h1234_5678, 1'b0); // R6 I/O single
        run_cycle(3'b010, IO_BASE[31:2] + 30'd3, 4'hC, 1'b0, 32'h0, 1'b0);
        run_cycle(3'b000, MEM_BASE[31:2], 4'hF, 1'b0, 32'h0, 1'b0); // R3
        run_cycle(3'b001, IO_BASE[31:2], 4'hF, 1'b0, 32'h0, 1'b0);  // R3
        run_cycle(3'b101, MEM_BASE[31:2], 4'hF, 1'b1, 32'h0, 1'b0); // R3
        run_cycle(3'b110, 30'h0040_0000, 4'hF, 1'b0, 32'h0, 1'b0); // R4
        run_cycle(3'b010, MEM_BASE[31:2], 4'hF, 1'b0, 32'h0, 1'b0); // R4 I/O in memory window
        run_cycle(3'b110, MEM_BASE[31:2] + 30'd2, 4'h3, 1'b0, 32'h0, 1'b1); // R11 single
        run_cycle(3'b111, MEM_BASE[31:2] + 30'd6, 4'hF, 1'b1, 32'h5A5A_0000, 1'b1); // R11 burst

        // constrained random
        for (int n = 0; n < 60; n++) begin
            logic [2:0] c;
            logic [3:0] s;
            c = 3'($urandom);
            s = 4'($urandom);
            if (s == 4'h0) s = 4'h1;
            run_cycle(c, pick_addr(int'($urandom % 3)), s, 1'($urandom), $urandom,
                      ($urandom % 5) == 0);
            if (($urandom % 2) == 0) @(negedge clk);
        end
        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 200000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule